// File: doc/BRIEF.md
# Serial Frame Master Shift Engine

This block is the master side of a synchronous serial link. It takes one transmit word through a valid/ready handshake and shifts it out most significant bit first. In the same frame it shifts in a word from the peripheral. It drives a serial clock that idles low, an active-low frame select and a transmit data line, and it samples a receive data line. Transmit data changes while the serial clock falls. Receive data is captured while the clock rises. When a frame finishes, the assembled receive word goes out as a one-cycle push toward a receive FIFO.

The serial bit period is set by a static divider input. Each half bit period lasts `div + 1` system clocks. The frame length comes from a size-minus-one input covering 4 to 32 bits, and it is captured when the frame starts. Frame select falls a full bit period ahead of the first rising clock edge and rises half a bit period after the last falling edge. Between consecutive frames, frame select stays high for at least one bit period. An enable input and a synchronous clear both force the outputs to their idle levels. The transmit line is driven low only by these two inputs and by reset. Otherwise it keeps the last bit sent.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, and in any cycle that follows a clock edge where `enable` was low: `sclk`=0, `txd`=0, `frm_n`=1 and `busy`=0. `tx_ready` is high only when `enable` is high and no frame or inter-frame gap is in progress.
- R2: A word is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both high. `frm_n` is low from the cycle after that edge. `tx_ready` stays low whenever `frm_n` is low.
- R3: With H = `div`+1, the first transmit bit appears on `txd` H cycles after `frm_n` falls. The first rising edge of `sclk` comes 2H cycles after `frm_n` falls.
- R4: `sclk` is high only while `frm_n` is low. It toggles every H cycles and gives exactly N rising edges per frame, where N is the frame length.
- R5: Transmit bits leave MSB first, taken from the low N bits of `tx_data`. `txd` changes inside a frame only while `sclk` is low: at the first half-bit boundary and at the falling edges of `sclk`.
- R6: `rxd` is sampled at each rising edge of `sclk`, MSB first. `rx_data` holds the N received bits right-justified, with all higher bits zero.
- R7: N = `dsize`+1 for `dsize` from 3 to 31. Values below 3 give N = 4. `dsize` is read only on the accepting edge.
- R8: `frm_n` returns high H cycles after the last falling edge of `sclk`, which is (2N+2)·H cycles after it fell. `rx_push` is a one-cycle pulse in that same cycle, and `rx_data` is updated in it.
- R9: After a frame ends normally, `txd` holds the last bit sent (bit 0 of the word) while idle.
- R10: Between two frames, `frm_n` stays high for at least 2H cycles. This includes a word that was already waiting when the previous frame ended.
- R11: Dropping `enable` in the middle of a frame aborts it. From the next cycle the outputs take their R1 levels, and that frame produces no `rx_push`.
- R12: A high `clr` on a clock edge has the effect of reset, and it also sets `rx_data` to zero. `busy` equals the inverse of `frm_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, same effect as reset |
| enable | input | 1 | Port enable; low forces idle levels |
| div | input | DIV_W | Half bit period minus one, in system clocks |
| dsize | input | SZ_W | Frame length minus one (3..31) |
| tx_data | input | DW | Transmit word, right-justified |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Engine can accept a word |
| rx_data | output | DW | Last received word, right-justified |
| rx_push | output | 1 | One-cycle push of a completed receive word |
| sclk | output | 1 | Serial clock, idles low |
| frm_n | output | 1 | Active-low frame select |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| busy | output | 1 | High while frame select is low |

## Verification
The assertions check properties that hold in every cycle. The serial clock never runs outside a frame. Handshake readiness and an active frame never overlap. `txd` never moves while `sclk` is high inside a frame. A receive sample is always followed by a rising `sclk`. A push only comes with the rising edge of frame select. Any cycle after `enable` is low shows idle levels. Other properties depend on the data and the scenario, and only the bench's cycle-by-cycle model can show them: the exact bit order on both lines, the 2H and (2N+2)·H placements, clamping of small sizes, the held last bit, the inter-frame gap when words arrive back to back, and the absence of a push after an abort or a clear.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } fm_state_e;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    tick   = run && (cnt_q == div);
    cnt_en = run || (cnt_q != '0);
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: the divider counter restarts from zero whenever the engine is idle
  a_r4_cnt_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 || run));
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_fm_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SZ_W   = 5,
  parameter int HALF_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            enable,
  input  logic            tick,
  input  logic            tx_valid,
  input  logic [SZ_W-1:0] dsize,
  output logic            tx_ready,
  output logic            run,
  output logic            load,
  output logic            tx_shift,
  output logic            rx_sample,
  output logic            done,
  output logic [SZ_W-1:0] size_eff,
  output logic            sclk,
  output logic            frm_n
);
  localparam logic [SZ_W-1:0] MIN_SZ = SZ_W'(3);
  localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'(DW-1);

  fm_state_e         state_q, state_d;
  logic [HALF_W-1:0] half_q, half_d, nh, two_n;
  logic [SZ_W:0]     nb_q, nb_d;
  logic              sclk_q, sclk_d, frm_q, frm_d;
  logic              st_en;

  always_comb begin
    if (dsize < MIN_SZ)      size_eff = MIN_SZ;
    else if (dsize > MAX_SZ) size_eff = MAX_SZ;
    else                     size_eff = dsize;
  end

  assign tx_ready = enable && (state_q == ST_IDLE);
  assign run      = (state_q != ST_IDLE);
  assign nh       = half_q + HALF_W'(1);
  assign two_n    = HALF_W'(nb_q) << 1;

  always_comb begin
    state_d   = state_q;
    half_d    = half_q;
    nb_d      = nb_q;
    sclk_d    = sclk_q;
    frm_d     = frm_q;
    load      = 1'b0;
    tx_shift  = 1'b0;
    rx_sample = 1'b0;
    done      = 1'b0;
    if (clr || !enable) begin
      state_d = ST_IDLE;
      half_d  = '0;
      sclk_d  = 1'b0;
      frm_d   = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (tx_valid) begin
            load    = 1'b1;
            state_d = ST_FRAME;
            half_d  = '0;
            frm_d   = 1'b0;
            nb_d    = {1'b0, size_eff} + (SZ_W+1)'(1);
          end
        end
        ST_FRAME: begin
          if (tick) begin
            half_d = nh;
            if (nh == two_n + HALF_W'(2)) begin
              done    = 1'b1;
              frm_d   = 1'b1;
              sclk_d  = 1'b0;
              state_d = ST_GAP;
              half_d  = '0;
            end else if (!nh[0]) begin
              sclk_d    = 1'b1;
              rx_sample = 1'b1;
            end else begin
              sclk_d = 1'b0;
              if (nh <= two_n - HALF_W'(1)) tx_shift = 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (nh == HALF_W'(2)) begin
              state_d = ST_IDLE;
              half_d  = '0;
            end else begin
              half_d = nh;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign st_en = clr || !enable || tick || (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      nb_q    <= (SZ_W+1)'(4);
      sclk_q  <= 1'b0;
      frm_q   <= 1'b1;
    end else if (st_en) begin
      state_q <= state_d;
      half_q  <= half_d;
      nb_q    <= nb_d;
      sclk_q  <= sclk_d;
      frm_q   <= frm_d;
    end
  end

  assign sclk  = sclk_q;
  assign frm_n = frm_q;

  // R4: serial clock runs only inside a frame
  a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !frm_q);
  // R2: no new word is offered while a frame is active
  a_r2_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> frm_q);
  // R7: the latched frame length stays within 4..DW during a frame
  a_r7_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_q |-> (nb_q >= (SZ_W+1)'(4) && nb_q <= (SZ_W+1)'(DW)));
  // R11: a cycle with enable low leaves clock low and frame high
  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (frm_q && !sclk_q));
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
  parameter int DW   = 32,
  parameter int SZ_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            enable,
  input  logic            load,
  input  logic [SZ_W-1:0] size_eff,
  input  logic [DW-1:0]   tx_data,
  input  logic            tx_shift,
  input  logic            rx_sample,
  input  logic            rxd,
  input  logic            done,
  output logic            txd,
  output logic [DW-1:0]   rx_data,
  output logic            rx_push
);
  localparam logic [SZ_W-1:0] TOP = SZ_W'(DW-1);

  logic [DW-1:0] tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d, rxo_q, rxo_d;
  logic          txd_q, txd_d, push_q, push_d;

  always_comb begin
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    rxo_d   = rxo_q;
    txd_d   = txd_q;
    push_d  = 1'b0;
    if (clr) begin
      tx_sh_d = '0;
      rx_sh_d = '0;
      rxo_d   = '0;
      txd_d   = 1'b0;
    end else if (!enable) begin
      txd_d = 1'b0;
    end else begin
      if (load) begin
        tx_sh_d = tx_data << (TOP - size_eff);
        rx_sh_d = '0;
      end
      if (tx_shift) begin
        txd_d   = tx_sh_q[DW-1];
        tx_sh_d = tx_sh_q << 1;
      end
      if (rx_sample) rx_sh_d = {rx_sh_q[DW-2:0], rxd};
      if (done) begin
        rxo_d  = rx_sh_q;
        push_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rxo_q   <= '0;
      txd_q   <= 1'b0;
      push_q  <= 1'b0;
    end else begin
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
      rxo_q   <= rxo_d;
      txd_q   <= txd_d;
      push_q  <= push_d;
    end
  end

  assign txd     = txd_q;
  assign rx_data = rxo_q;
  assign rx_push = push_q;

  // R8: the push is a single-cycle pulse
  a_r8_push_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |=> !push_q);
  // R1: the transmit line is low after any cycle with enable low
  a_r1_txd_low_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !txd_q);
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int DW    = 32,
  parameter int DIV_W = 8,
  parameter int SZ_W  = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  input  logic [SZ_W-1:0]  dsize,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [DW-1:0]    rx_data,
  output logic             rx_push,
  output logic             sclk,
  output logic             frm_n,
  output logic             txd,
  input  logic             rxd,
  output logic             busy
);
  localparam int HALF_W = $clog2(2*DW + 3);

  logic            tick, run, load, tx_shift, rx_sample, done;
  logic [SZ_W-1:0] size_eff;

  spi_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
  );

  spi_frame_ctrl #(.DW(DW), .SZ_W(SZ_W), .HALF_W(HALF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .enable(enable), .tick(tick),
    .tx_valid(tx_valid), .dsize(dsize), .tx_ready(tx_ready), .run(run),
    .load(load), .tx_shift(tx_shift), .rx_sample(rx_sample), .done(done),
    .size_eff(size_eff), .sclk(sclk), .frm_n(frm_n)
  );

  spi_shift_path #(.DW(DW), .SZ_W(SZ_W)) u_path (
    .clk(clk), .rst_n(rst_n), .clr(clr), .enable(enable), .load(load),
    .size_eff(size_eff), .tx_data(tx_data), .tx_shift(tx_shift),
    .rx_sample(rx_sample), .rxd(rxd), .done(done), .txd(txd),
    .rx_data(rx_data), .rx_push(rx_push)
  );

  assign busy = !frm_n;

  // R8: a receive push only appears as frame select returns high
  a_r8_push_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $rose(frm_n));
  // R5: inside a frame, txd moves only while the serial clock is low
  a_r5_txd_moves_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_n && $past(!frm_n) && !$stable(txd)) |-> !sclk);
  // R6: every receive sample coincides with a rising serial clock
  a_r6_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sample |=> $rose(sclk));
endmodule

// File: tb/tb_spi_frame_master.sv
module tb_spi_frame_master;
  localparam int DW = 32;
  localparam int DIV_W = 8;
  localparam int SZ_W = 5;

  logic clk, rst_n, clr, enable, tx_valid, rxd;
  logic [DIV_W-1:0] div;
  logic [SZ_W-1:0]  dsize;
  logic [DW-1:0]    tx_data, rx_data;
  logic tx_ready, rx_push, sclk, frm_n, txd, busy;

  int checks = 0;
  int fails  = 0;

  spi_frame_master #(.DW(DW), .DIV_W(DIV_W), .SZ_W(SZ_W)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .enable(enable), .div(div),
    .dsize(dsize), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_push(rx_push),
    .sclk(sclk), .frm_n(frm_n), .txd(txd), .rxd(rxd), .busy(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mode = 0, m_e = 0, m_g = 0, m_n = 4;
  logic [DW-1:0] m_word = '0, m_pw = '0, m_rx = '0;
  logic m_frm = 1, m_sclk = 0, m_txd = 0, m_push = 0;

  always @(posedge clk) begin
    int h, b, hh;
    hh = int'(div) + 1;
    m_push = 0;
    if (!rst_n || clr) begin
      m_mode = 0; m_txd = 0; m_rx = '0; m_frm = 1; m_sclk = 0;
    end else if (!enable) begin
      m_mode = 0; m_txd = 0; m_frm = 1; m_sclk = 0;
    end else begin
      case (m_mode)
        0: if (tx_valid) begin
             m_mode = 1; m_e = 0;
             m_n = ((int'(dsize) < 3) ? 3 : int'(dsize)) + 1;
             m_word = tx_data;
             m_pw = tx_data ^ 32'h5AC3_96E1;
           end
        1: m_e++;
        2: begin
             m_g++;
             if (m_g == 2*hh) m_mode = 0;
           end
        default: m_mode = 0;
      endcase
      if (m_mode == 1) begin
        h = m_e / hh;
        if (h == 2*m_n + 2) begin
          m_mode = 2; m_g = 0; m_frm = 1; m_sclk = 0; m_push = 1;
          m_rx = DW'((64'(m_pw)) & ((64'd1 << m_n) - 64'd1));
        end else begin
          m_frm = 0;
          m_sclk = (h >= 2 && h <= 2*m_n && h % 2 == 0);
          if (h >= 1) begin
            b = (h - 1) / 2;
            if (b > m_n - 1) b = m_n - 1;
            m_txd = m_word[m_n - 1 - b];
          end
        end
      end
    end
  end

  // ---------------- peripheral and monitors ----------------
  logic p_frm = 1, p_sclk = 0;
  int   p_idx = 0, rises = 0, hi_cnt = 0, last_gap = 0;
  initial rxd = 1'b0;

  always @(negedge clk) begin
    if (p_frm && !frm_n) begin
      p_idx = m_n - 1;
      rxd = m_pw[p_idx];
      rises = 0;
      last_gap = hi_cnt;
      hi_cnt = 0;
    end else if (p_sclk && !sclk && !frm_n) begin
      p_idx--;
      if (p_idx >= 0) rxd = m_pw[p_idx];
    end
    if (sclk && !p_sclk) rises++;
    if (frm_n) hi_cnt++;
    p_frm = frm_n;
    p_sclk = sclk;
    if (rst_n) begin
      chk(frm_n == m_frm, "R3 R8 frm_n", frm_n, m_frm);
      chk(sclk == m_sclk, "R4 sclk", sclk, m_sclk);
      chk(txd == m_txd, "R5 txd", txd, m_txd);
      chk(rx_push == m_push, "R8 rx_push", rx_push, m_push);
      chk(rx_data == m_rx, "R6 rx_data", rx_data, m_rx);
      chk(tx_ready == (enable && m_mode == 0), "R2 tx_ready", tx_ready, (enable && m_mode == 0));
      chk(busy == !m_frm, "R12 busy", busy, !m_frm);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [DW-1:0] w, input int sz);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = w; dsize = SZ_W'(sz);
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_push();
    do @(negedge clk); while (!rx_push);
  endtask

  initial begin
    rst_n = 0; clr = 0; enable = 0; tx_valid = 0; tx_data = '0; dsize = 5'd7; div = 8'd2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset levels with enable low
    chk(frm_n && !sclk && !txd && !busy && !tx_ready, "R1 reset idle", {frm_n, sclk, txd, busy, tx_ready}, 5'b10000);
    enable = 1;
    @(negedge clk);
    chk(tx_ready, "R1 ready when enabled", tx_ready, 1);

    // 8-bit frame, div=2
    send(32'h0000_00A5, 7);
    wait_push();
    chk(rises == 8, "R4 rising edges 8-bit", rises, 8);
    chk(rx_data == ((32'h0000_00A5 ^ 32'h5AC3_96E1) & 32'hFF), "R6 rx word 8-bit", rx_data, (32'h0000_00A5 ^ 32'h5AC3_96E1) & 32'hFF);
    repeat (10) @(negedge clk);
    chk(txd == 1'b1, "R9 txd holds last bit", txd, 1);

    // 32-bit frame
    send(32'h8001_7FFE, 31);
    wait_push();
    chk(rises == 32, "R4 rising edges 32-bit", rises, 32);
    repeat (8) @(negedge clk);
    chk(txd == 1'b0, "R9 txd holds last bit 0", txd, 0);

    // size clamp: dsize 0 -> 4 bits
    send(32'hFFFF_FFF9, 0);
    wait_push();
    chk(rises == 4, "R7 clamp to 4 bits", rises, 4);
    chk(rx_data[DW-1:4] == '0, "R6 upper bits zero", rx_data, 0);

    // back to back with div=0
    div = 8'd0;
    send(32'h0000_0C3A, 11);
    send(32'h0000_0555, 11);
    chk(last_gap >= 2, "R10 gap one bit period div0", last_gap, 2);
    wait_push();
    chk(rises == 12, "R7 12-bit frame", rises, 12);

    // back to back with div=3
    div = 8'd3;
    send(32'h0000_0013, 4);
    send(32'h0000_001C, 4);
    chk(last_gap >= 8, "R10 gap one bit period div3", last_gap, 8);
    wait_push();

    // abort by enable
    div = 8'd2;
    send(32'h1234_5678, 23);
    repeat (20) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk(frm_n && !sclk && !txd && !rx_push, "R11 abort idle", {frm_n, sclk, txd, rx_push}, 4'b1000);
    enable = 1;
    repeat (30) @(negedge clk);
    chk(!rx_push && frm_n, "R11 no push after abort", rx_push, 0);

    // clear mid frame
    send(32'h0000_7E81, 15);
    repeat (25) @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    chk(frm_n && !sclk && !txd && rx_data == '0, "R12 clear", {frm_n, sclk, txd}, 3'b100);
    send(32'h0000_0009, 3);
    wait_push();
    chk(rises == 4, "R7 4-bit after clear", rises, 4);
    repeat (10) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule